// File: doc/BRIEF.md
# Switch Reset and Port State Sequencer

This controller brings a multiport Ethernet switch into a known state through a simple register-access port. The port carries a device address, a register number, write data and a read/write flag. The controller raises a request and holds it until the transport returns an acknowledge. With that acknowledge come the read data and an error flag. The transport itself lies outside the block.

An init command starts the full sequence. The controller first reads the switch identifier and works out from it where the port registers live and how many ports the switch has. It then takes every port out of service, one after another. Next it waits a fixed drain time so the queues can empty. It then sets the self-clearing software-reset bit in the global control register and polls that bit once per millisecond until it clears or the poll budget runs out.

Once the sequence has finished cleanly, single ports can be put into forwarding or back into disabled with a read-modify-write of their 2-bit state field. Every finished operation produces a one-cycle done pulse and a 2-bit status code.

Top module: `sw_reset_seq`

## Requirements
- R1: After reset, busy_o, done_o, ready_o and acc_req_o are all 0.
- R2: A request stays high with unchanged device, register, write data and direction until it is acknowledged, and each acknowledge completes exactly one access.
- R3: The identifier is register 3 of device 0x10, masked with 0xFFF0. If the masked value is 0xFFF0, the read is repeated at device 0x08. The port registers then start at the base that answered, and the global control register is register 4 of device 0x1B for base 0x10 or of device 0x0F for base 0x08.
- R4: Masked identifiers 0x0980, 0x0990, 0x1720, 0x1760, 0x2400 and 0x3520 give 11 ports. Identifiers 0x0200, 0x0700, 0x0710, 0x2200, 0x2500 and 0x1150 give 7 ports. Any other identifier, or 0xFFF0 at both bases, ends the sequence with status 1 and no port write.
- R5: Ports 0 to N-1 are disabled in ascending order. For each one, register 4 at base+port is read, then written back with bits 1:0 set to 0 and all other bits kept.
- R6: At least DRAIN_MS milliseconds, each CLK_KHZ cycles long, pass between the last port write and the reset write.
- R7: The reset is a read of the global control register followed by a write of that value with bit 15 set.
- R8: The global control register is then read until bit 15 reads 0, with at least one millisecond between reads. The sequence then ends with status 0 and ready_o set to 1.
- R9: If bit 15 is still 1 on the POLL_LIMIT-th read, the sequence ends with status 2 and ready_o stays 0.
- R10: An acknowledge that carries the error flag stops the sequence at once with status 3, and no further access is made.
- R11: While idle and ready, a port request with port_sel_i below the port count reads that port's register 4. It then writes the value back with bits 1:0 set to 3 (enable) or 0 (disable), keeping the other bits, and finishes with status 0.
- R12: A port request made while not ready, or with port_sel_i at or above the port count, is ignored: no access is made and there is no done pulse.
- R13: done_o is a single-cycle pulse. switch_id_o and nports_o report the masked identifier and the port count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Start the identify, disable, drain and reset sequence |
| port_req_i | input | 1 | Request a change to one port's state |
| port_en_i | input | 1 | 1 sets forwarding, 0 sets disabled |
| port_sel_i | input | 4 | Port index for the request |
| acc_req_o | output | 1 | Register access request |
| acc_we_o | output | 1 | 1 for a write, 0 for a read |
| acc_dev_o | output | 5 | Device address |
| acc_reg_o | output | 5 | Register number |
| acc_wdata_o | output | 16 | Write data |
| acc_ack_i | input | 1 | Access complete |
| acc_err_i | input | 1 | Access failed (valid with ack) |
| acc_rdata_i | input | 16 | Read data (valid with ack) |
| busy_o | output | 1 | An operation is running |
| done_o | output | 1 | One-cycle pulse when an operation ends |
| status_o | output | 2 | 0 ok, 1 no device, 2 timeout, 3 access error |
| ready_o | output | 1 | Last init finished cleanly |
| nports_o | output | 4 | Port count found |
| switch_id_o | output | 16 | Masked switch identifier |

## Verification
The bench builds the block with CLK_KHZ = 16, DRAIN_MS = 2 and the default POLL_LIMIT of 1000. With these values one millisecond is 16 cycles, so the drain gap and the poll spacing can be measured exactly against a short window. The full 1000-read timeout also fits in about twenty thousand cycles. The port counts stay at 11 and 7, which covers both address bases and both family sizes, including the fallback probe at 0x08.

// File: rtl/sw_seq_pkg.sv
package sw_seq_pkg;

  localparam int DATA_W = 16;
  localparam int DEV_W  = 5;
  localparam int REG_W  = 5;
  localparam int NUM_FAM_IDS = 6;

  // Register numbers inside a device
  localparam logic [REG_W-1:0] REG_IDENT = 5'd3;
  localparam logic [REG_W-1:0] REG_CTRL  = 5'd4;

  // Device address pairs: primary and fallback layout
  localparam logic [DEV_W-1:0] PBASE_PRI = 5'h10;
  localparam logic [DEV_W-1:0] PBASE_ALT = 5'h08;
  localparam logic [DEV_W-1:0] GLB_PRI   = 5'h1B;
  localparam logic [DEV_W-1:0] GLB_ALT   = 5'h0F;

  localparam int RST_BIT = 15;
  localparam logic [DATA_W-1:0] ID_MASK   = 16'hFFF0;
  localparam logic [DATA_W-1:0] ID_ABSENT = 16'hFFF0;

  localparam logic [1:0] PST_OFF = 2'b00;
  localparam logic [1:0] PST_FWD = 2'b11;

  localparam logic [NUM_FAM_IDS-1:0][DATA_W-1:0] WIDE_IDS = {
    16'h3520, 16'h2400, 16'h1760, 16'h1720, 16'h0990, 16'h0980
  };
  localparam logic [NUM_FAM_IDS-1:0][DATA_W-1:0] NARROW_IDS = {
    16'h1150, 16'h2500, 16'h2200, 16'h0710, 16'h0700, 16'h0200
  };

  typedef enum logic [1:0] {
    STAT_OK      = 2'd0,
    STAT_NODEV   = 2'd1,
    STAT_TIMEOUT = 2'd2,
    STAT_ACCERR  = 2'd3
  } seq_status_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ID_RD,
    S_DIS_RD,
    S_DIS_WR,
    S_DRAIN,
    S_GRST_RD,
    S_GRST_WR,
    S_POLL_RD,
    S_POLL_WAIT,
    S_PORT_RD,
    S_PORT_WR,
    S_FINISH
  } seq_state_e;

endpackage

// File: rtl/sw_seq_ms_timer.sv
module sw_seq_ms_timer #(
  parameter int CYC_PER_MS = 1000,
  parameter int MS_W       = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            done_o
);

  localparam int PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CYC_PER_MS - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [MS_W-1:0]  ms_q, ms_d;
  logic             run_q, run_d;
  logic             done_q, done_d;
  logic             pre_en, ms_en;

  always_comb begin
    pre_d  = pre_q;
    ms_d   = ms_q;
    run_d  = run_q;
    done_d = 1'b0;
    pre_en = 1'b0;
    ms_en  = 1'b0;
    if (start_i) begin
      pre_d  = PRE_MAX;
      ms_d   = ms_i;
      run_d  = 1'b1;
      pre_en = 1'b1;
      ms_en  = 1'b1;
    end else if (run_q) begin
      pre_en = 1'b1;
      if (pre_q == '0) begin
        pre_d = PRE_MAX;
        ms_en = 1'b1;
        if (ms_q == MS_W'(1)) begin
          run_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          ms_d = ms_q - MS_W'(1);
        end
      end else begin
        pre_d = pre_q - PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      ms_q   <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (pre_en) pre_q <= pre_d;
      if (ms_en)  ms_q  <= ms_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  // R6
  tmr_ms_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (ms_q != '0));

  // R6
  tmr_done_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !run_q);

endmodule

// File: rtl/sw_seq_acc.sv
module sw_seq_acc #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              ack_i,
  input  logic              err_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              req_o,
  output logic              fin_o,
  output logic              fail_o,
  output logic [DATA_W-1:0] data_o
);

  logic              req_q, req_d;
  logic [DATA_W-1:0] data_q;
  logic              cap_en;

  always_comb begin
    if (req_q) req_d = !ack_i;
    else       req_d = go_i;
  end

  assign fin_o  = req_q & ack_i & !err_i;
  assign fail_o = req_q & ack_i & err_i;
  assign cap_en = fin_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      data_q <= '0;
    end else begin
      req_q <= req_d;
      if (cap_en) data_q <= rdata_i;
    end
  end

  assign req_o  = req_q;
  assign data_o = data_q;

  // R2
  ack_pairs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> req_q);

  // R2
  ack_drops_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && ack_i) |=> !req_q);

endmodule

// File: rtl/sw_seq_id_class.sv
module sw_seq_id_class
  import sw_seq_pkg::*;
#(
  parameter int WIDE_PORTS   = 11,
  parameter int NARROW_PORTS = 7,
  parameter int PORT_W       = 4
) (
  input  logic [DATA_W-1:0] id_i,
  output logic              known_o,
  output logic [PORT_W-1:0] nports_o
);

  logic [NUM_FAM_IDS-1:0] wide_hit, narrow_hit;

  for (genvar g = 0; g < NUM_FAM_IDS; g++) begin : g_match
    assign wide_hit[g]   = (id_i == WIDE_IDS[g]);
    assign narrow_hit[g] = (id_i == NARROW_IDS[g]);
  end

  always_comb begin
    known_o  = 1'b1;
    nports_o = '0;
    if (|wide_hit)        nports_o = PORT_W'(WIDE_PORTS);
    else if (|narrow_hit) nports_o = PORT_W'(NARROW_PORTS);
    else                  known_o  = 1'b0;
  end

endmodule

// File: rtl/sw_reset_seq.sv
module sw_reset_seq
  import sw_seq_pkg::*;
#(
  parameter int CLK_KHZ      = 100000,
  parameter int DRAIN_MS     = 2,
  parameter int POLL_LIMIT   = 1000,
  parameter int WIDE_PORTS   = 11,
  parameter int NARROW_PORTS = 7,
  parameter int PORT_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              port_req_i,
  input  logic              port_en_i,
  input  logic [PORT_W-1:0] port_sel_i,
  output logic              acc_req_o,
  output logic              acc_we_o,
  output logic [DEV_W-1:0]  acc_dev_o,
  output logic [REG_W-1:0]  acc_reg_o,
  output logic [DATA_W-1:0] acc_wdata_o,
  input  logic              acc_ack_i,
  input  logic              acc_err_i,
  input  logic [DATA_W-1:0] acc_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic              ready_o,
  output logic [PORT_W-1:0] nports_o,
  output logic [DATA_W-1:0] switch_id_o
);

  localparam int MS_W      = $clog2(DRAIN_MS + 2);
  localparam int POLL_W    = $clog2(POLL_LIMIT + 1);
  localparam int DRAIN_CYC = CLK_KHZ * DRAIN_MS;
  localparam int CHK_W     = $clog2(DRAIN_CYC + 2) + 1;

  seq_state_e        state_q, state_d;
  logic              alt_q, alt_d;
  logic [DATA_W-1:0] id_q, id_d;
  logic [PORT_W-1:0] nports_q, nports_d;
  logic [PORT_W-1:0] port_q, port_d;
  logic [POLL_W-1:0] polls_q, polls_d;
  seq_status_e       status_q, status_d;
  logic              ready_q, ready_d;
  logic              op_en_q, op_en_d;

  logic              go, fin, fail;
  logic [DATA_W-1:0] rd_data;
  logic              tmr_start, tmr_done;
  logic [MS_W-1:0]   tmr_ms;
  logic [DATA_W-1:0] id_masked;
  logic              id_known;
  logic [PORT_W-1:0] id_nports;
  logic [DEV_W-1:0]  pbase, gdev, pdev;

  // Access engine
  sw_seq_acc #(.DATA_W(DATA_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .ack_i   (acc_ack_i),
    .err_i   (acc_err_i),
    .rdata_i (acc_rdata_i),
    .req_o   (acc_req_o),
    .fin_o   (fin),
    .fail_o  (fail),
    .data_o  (rd_data)
  );

  // Millisecond delays
  sw_seq_ms_timer #(.CYC_PER_MS(CLK_KHZ), .MS_W(MS_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .ms_i    (tmr_ms),
    .done_o  (tmr_done)
  );

  // Family lookup
  assign id_masked = acc_rdata_i & ID_MASK;

  sw_seq_id_class #(
    .WIDE_PORTS   (WIDE_PORTS),
    .NARROW_PORTS (NARROW_PORTS),
    .PORT_W       (PORT_W)
  ) u_cls (
    .id_i     (id_masked),
    .known_o  (id_known),
    .nports_o (id_nports)
  );

  assign pbase = alt_q ? PBASE_ALT : PBASE_PRI;
  assign gdev  = alt_q ? GLB_ALT   : GLB_PRI;
  assign pdev  = pbase + DEV_W'(port_q);

  // Access fields, held by state while a request is outstanding
  always_comb begin
    go          = 1'b0;
    acc_we_o    = 1'b0;
    acc_dev_o   = pdev;
    acc_reg_o   = REG_CTRL;
    acc_wdata_o = '0;
    unique case (state_q)
      S_ID_RD: begin
        go        = 1'b1;
        acc_dev_o = pbase;
        acc_reg_o = REG_IDENT;
      end
      S_DIS_RD, S_PORT_RD: go = 1'b1;
      S_DIS_WR: begin
        go          = 1'b1;
        acc_we_o    = 1'b1;
        acc_wdata_o = {rd_data[DATA_W-1:2], PST_OFF};
      end
      S_PORT_WR: begin
        go          = 1'b1;
        acc_we_o    = 1'b1;
        acc_wdata_o = {rd_data[DATA_W-1:2], op_en_q ? PST_FWD : PST_OFF};
      end
      S_GRST_RD, S_POLL_RD: begin
        go        = 1'b1;
        acc_dev_o = gdev;
      end
      S_GRST_WR: begin
        go          = 1'b1;
        acc_we_o    = 1'b1;
        acc_dev_o   = gdev;
        acc_wdata_o = rd_data | (DATA_W'(1) << RST_BIT);
      end
      default: ;
    endcase
  end

  // Sequencer next state
  always_comb begin
    state_d   = state_q;
    alt_d     = alt_q;
    id_d      = id_q;
    nports_d  = nports_q;
    port_d    = port_q;
    polls_d   = polls_q;
    status_d  = status_q;
    ready_d   = ready_q;
    op_en_d   = op_en_q;
    tmr_start = 1'b0;
    tmr_ms    = MS_W'(1);

    if (fail) begin
      state_d  = S_FINISH;
      status_d = STAT_ACCERR;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (init_i) begin
            state_d = S_ID_RD;
            alt_d   = 1'b0;
            ready_d = 1'b0;
          end else if (port_req_i && ready_q && (port_sel_i < nports_q)) begin
            state_d = S_PORT_RD;
            port_d  = port_sel_i;
            op_en_d = port_en_i;
          end
        end
        S_ID_RD: if (fin) begin
          if (id_masked == ID_ABSENT) begin
            if (!alt_q) begin
              alt_d = 1'b1;
            end else begin
              id_d     = id_masked;
              state_d  = S_FINISH;
              status_d = STAT_NODEV;
            end
          end else begin
            id_d = id_masked;
            if (id_known) begin
              nports_d = id_nports;
              port_d   = '0;
              state_d  = S_DIS_RD;
            end else begin
              state_d  = S_FINISH;
              status_d = STAT_NODEV;
            end
          end
        end
        S_DIS_RD: if (fin) state_d = S_DIS_WR;
        S_DIS_WR: if (fin) begin
          if (port_q == nports_q - PORT_W'(1)) begin
            state_d   = S_DRAIN;
            tmr_start = 1'b1;
            tmr_ms    = MS_W'(DRAIN_MS);
          end else begin
            port_d  = port_q + PORT_W'(1);
            state_d = S_DIS_RD;
          end
        end
        S_DRAIN:   if (tmr_done) state_d = S_GRST_RD;
        S_GRST_RD: if (fin) state_d = S_GRST_WR;
        S_GRST_WR: if (fin) begin
          state_d = S_POLL_RD;
          polls_d = '0;
        end
        S_POLL_RD: if (fin) begin
          if (!acc_rdata_i[RST_BIT]) begin
            state_d  = S_FINISH;
            status_d = STAT_OK;
            ready_d  = 1'b1;
          end else if (polls_q == POLL_W'(POLL_LIMIT - 1)) begin
            state_d  = S_FINISH;
            status_d = STAT_TIMEOUT;
          end else begin
            polls_d   = polls_q + POLL_W'(1);
            state_d   = S_POLL_WAIT;
            tmr_start = 1'b1;
          end
        end
        S_POLL_WAIT: if (tmr_done) state_d = S_POLL_RD;
        S_PORT_RD:   if (fin) state_d = S_PORT_WR;
        S_PORT_WR: if (fin) begin
          state_d  = S_FINISH;
          status_d = STAT_OK;
        end
        S_FINISH: state_d = S_IDLE;
        default:  state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      alt_q    <= 1'b0;
      id_q     <= '0;
      nports_q <= '0;
      port_q   <= '0;
      polls_q  <= '0;
      status_q <= STAT_OK;
      ready_q  <= 1'b0;
      op_en_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      alt_q    <= alt_d;
      id_q     <= id_d;
      nports_q <= nports_d;
      port_q   <= port_d;
      polls_q  <= polls_d;
      status_q <= status_d;
      ready_q  <= ready_d;
      op_en_q  <= op_en_d;
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FINISH);
  assign status_o    = status_q;
  assign ready_o     = ready_q;
  assign nports_o    = nports_q;
  assign switch_id_o = id_q;

  // Cycles since the last port-disable write completed (checking only)
  logic [CHK_W-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          gap_q <= '0;
    else if (state_q == S_DIS_WR && fin)  gap_q <= '0;
    else if (gap_q != {CHK_W{1'b1}})      gap_q <= gap_q + CHK_W'(1);
  end

  // R2
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_o && !acc_ack_i) |=> (acc_req_o && $stable(acc_dev_o) && $stable(acc_reg_o)
                                   && $stable(acc_wdata_o) && $stable(acc_we_o)));

  // R6
  drain_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_o && acc_we_o && state_q == S_GRST_WR) |-> (gap_q >= CHK_W'(DRAIN_CYC)));

  // R9
  poll_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    polls_q < POLL_W'(POLL_LIMIT));

  // R13
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  ready_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (done_o && status_o == STAT_OK));

  // R12
  req_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_o |-> busy_o);

endmodule

// File: tb/sw_reset_seq_tb_top.sv
module sw_reset_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int KHZ        = 16;
  localparam int DRAIN      = 2;
  localparam int PLIM       = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_i = 1'b0, port_req_i = 1'b0, port_en_i = 1'b0;
  logic [3:0]  port_sel_i = '0;
  logic        acc_req, acc_we, ack = 1'b0, err = 1'b0;
  logic [4:0]  acc_dev, acc_reg;
  logic [15:0] acc_wdata, rdata = '0;
  logic        busy, done, ready;
  logic [1:0]  status;
  logic [3:0]  nports;
  logic [15:0] sw_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_reset_seq #(.CLK_KHZ(KHZ), .DRAIN_MS(DRAIN), .POLL_LIMIT(PLIM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init_i), .port_req_i(port_req_i),
    .port_en_i(port_en_i), .port_sel_i(port_sel_i), .acc_req_o(acc_req),
    .acc_we_o(acc_we), .acc_dev_o(acc_dev), .acc_reg_o(acc_reg),
    .acc_wdata_o(acc_wdata), .acc_ack_i(ack), .acc_err_i(err),
    .acc_rdata_i(rdata), .busy_o(busy), .done_o(done), .status_o(status),
    .ready_o(ready), .nports_o(nports), .switch_id_o(sw_id)
  );

  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // Register file model
  logic [15:0] mem [0:1023];
  int  n_acc, n_pwr, n_poll, err_at, clr_after, pend;
  int  t_last_pwr, t_rst_wr, t_poll, gap_min, gap_max;
  int  order_bad;
  logic [4:0]  exp_g1, exp_base;
  logic [15:0] rst_wdata;
  bit  rst_written;

  function automatic logic [15:0] pat(input int d);
    return 16'h5A03 ^ 16'(d << 4);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      ack = 1'b0; err = 1'b0;
    end else if (acc_req && !ack) begin
      ack = 1'b1; err = 1'b0;
      if (n_acc == err_at) begin
        err = 1'b1;
      end else if (acc_we) begin
        if (acc_dev == exp_g1 && acc_reg == 5'd4) begin
          if (acc_wdata[15]) begin
            rst_written = 1'b1; pend = clr_after; t_rst_wr = cyc; rst_wdata = acc_wdata;
          end
        end else if (acc_reg == 5'd4) begin
          if (acc_dev != exp_base + 5'(n_pwr)) order_bad++;
          n_pwr++; t_last_pwr = cyc;
        end
        mem[{acc_dev, acc_reg}] = acc_wdata;
      end else begin
        if (acc_dev == exp_g1 && acc_reg == 5'd4 && rst_written) begin
          if (pend == 0) mem[{acc_dev, acc_reg}][15] = 1'b0;
          if (pend > 0) pend--;
          n_poll++;
          if (n_poll > 1) begin
            if (cyc - t_poll < gap_min) gap_min = cyc - t_poll;
            if (cyc - t_poll > gap_max) gap_max = cyc - t_poll;
          end
          t_poll = cyc;
        end
        rdata = mem[{acc_dev, acc_reg}];
      end
      n_acc++;
    end else begin
      ack = 1'b0; err = 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [4:0] base, input logic [4:0] g1);
    for (int i = 0; i < 1024; i++) mem[i] = 16'hFFFF;
    for (int d = 0; d < 32; d++) mem[{5'(d), 5'd4}] = pat(d);
    exp_base = base; exp_g1 = g1;
    n_acc = 0; n_pwr = 0; n_poll = 0; err_at = -1; clr_after = 0; pend = -1;
    t_last_pwr = 0; t_rst_wr = 0; t_poll = 0; gap_min = 1 << 30; gap_max = 0;
    order_bad = 0; rst_written = 1'b0; rst_wdata = '0;
  endtask

  task automatic run_init(input string tag);
    int n;
    n = 0;
    @(negedge clk) init_i = 1'b1;
    @(negedge clk) init_i = 1'b0;
    while (!done && n < 40000) begin @(negedge clk); n++; end
    check(done, {tag, " done seen"}, done, 1);
  endtask

  task automatic ports_cleared(input int base, input int cnt, output int bad);
    bad = 0;
    for (int p = 0; p < cnt; p++)
      if (mem[{5'(base + p), 5'd4}] != (pat(base + p) & 16'hFFFC)) bad++;
  endtask

  task automatic t_reset_state();
    check(!busy && !done && !ready && !acc_req, "R1 reset outputs idle",
          {busy, done, ready, acc_req}, 0);
  endtask

  task automatic t_primary();
    int bad;
    setup(5'h10, 5'h1B);
    mem[{5'h10, 5'd3}] = 16'h1761;
    mem[{5'h1B, 5'd4}] = 16'h4321;
    clr_after = 3;
    run_init("R8 primary");
    check(status == 2'd0, "R8 status ok", status, 0);
    check(ready, "R8 ready", ready, 1);
    check(sw_id == 16'h1760, "R13 id reported masked (R3)", sw_id, 16'h1760);
    check(nports == 4'd11, "R4 wide family 11 ports", nports, 11);
    @(negedge clk);
    check(!done, "R13 done single cycle", done, 0);
    ports_cleared(16, 11, bad);
    check(bad == 0, "R5 ports cleared, other bits kept", bad, 0);
    check(n_pwr == 11 && order_bad == 0, "R5 one write per port in order", n_pwr, 11);
    check(rst_wdata == 16'hC321, "R7 reset write keeps bits", rst_wdata, 16'hC321);
    check(t_rst_wr - t_last_pwr >= DRAIN*KHZ && t_rst_wr - t_last_pwr <= DRAIN*KHZ + 8,
          "R6 drain gap", t_rst_wr - t_last_pwr, DRAIN*KHZ);
    check(n_poll == 4, "R8 polls until clear", n_poll, 4);
    check(gap_min >= KHZ && gap_max <= KHZ + 6, "R8 poll spacing", gap_min, KHZ);
    check(mem[{5'h1B, 5'd4}] == 16'h4321, "R7 reset bit self-cleared", mem[{5'h1B, 5'd4}], 16'h4321);
    check(n_acc == 29, "R2 access count", n_acc, 29);
  endtask

  task automatic t_fallback_and_ports();
    int bad, a0;
    setup(5'h08, 5'h0F);
    mem[{5'h08, 5'd3}] = 16'h071A;
    mem[{5'h0F, 5'd4}] = 16'h0123;
    clr_after = 0;
    run_init("R3 fallback");
    check(status == 2'd0 && ready, "R3 fallback ok", status, 0);
    check(nports == 4'd7 && sw_id == 16'h0710, "R4 narrow family 7 ports", nports, 7);
    ports_cleared(8, 7, bad);
    check(bad == 0 && n_pwr == 7 && order_bad == 0, "R3 ports at base 0x08", bad, 0);
    check(rst_wdata == 16'h8123 && n_poll == 1, "R3 global at 0x0F", rst_wdata, 16'h8123);
    // enable port 2
    a0 = n_acc;
    @(negedge clk) begin port_req_i = 1'b1; port_en_i = 1'b1; port_sel_i = 4'd2; end
    @(negedge clk) port_req_i = 1'b0;
    for (int i = 0; i < 20 && !done; i++) @(negedge clk);
    check(done && status == 2'd0, "R11 enable done", status, 0);
    check(mem[{5'h0A, 5'd4}] == (pat(10) | 16'h0003), "R11 enable sets 3",
          mem[{5'h0A, 5'd4}], pat(10) | 16'h0003);
    check(n_acc - a0 == 2, "R11 one read one write", n_acc - a0, 2);
    // disable port 2
    @(negedge clk) begin port_req_i = 1'b1; port_en_i = 1'b0; port_sel_i = 4'd2; end
    @(negedge clk) port_req_i = 1'b0;
    for (int i = 0; i < 20 && !done; i++) @(negedge clk);
    check(mem[{5'h0A, 5'd4}] == (pat(10) & 16'hFFFC), "R11 disable sets 0",
          mem[{5'h0A, 5'd4}], pat(10) & 16'hFFFC);
    // out of range port 7
    @(negedge clk);
    a0 = n_acc; bad = 0;
    @(negedge clk) begin port_req_i = 1'b1; port_en_i = 1'b1; port_sel_i = 4'd7; end
    @(negedge clk) port_req_i = 1'b0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (done) bad++; end
    check(n_acc == a0 && bad == 0, "R12 out-of-range port ignored", n_acc - a0, 0);
  endtask

  task automatic t_unknown();
    int a0, bad;
    setup(5'h10, 5'h1B);
    mem[{5'h10, 5'd3}] = 16'h1234;
    run_init("R4 unknown");
    check(status == 2'd1 && !ready, "R4 unknown id no device", status, 1);
    check(n_pwr == 0 && sw_id == 16'h1230, "R4 no port writes", n_pwr, 0);
    @(negedge clk);
    a0 = n_acc; bad = 0;
    @(negedge clk) begin port_req_i = 1'b1; port_en_i = 1'b1; port_sel_i = 4'd0; end
    @(negedge clk) port_req_i = 1'b0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (done) bad++; end
    check(n_acc == a0 && bad == 0, "R12 request while not ready ignored", n_acc - a0, 0);
  endtask

  task automatic t_absent();
    setup(5'h10, 5'h1B);
    run_init("R4 absent");
    check(status == 2'd1 && n_acc == 2, "R4 absent at both bases", n_acc, 2);
  endtask

  task automatic t_timeout();
    setup(5'h10, 5'h1B);
    mem[{5'h10, 5'd3}] = 16'h3527;
    mem[{5'h1B, 5'd4}] = 16'h0000;
    clr_after = -1;
    run_init("R9 timeout");
    check(status == 2'd2 && !ready, "R9 timeout status", status, 2);
    check(n_poll == PLIM, "R9 poll budget", n_poll, PLIM);
  endtask

  task automatic t_accerr();
    int n;
    setup(5'h10, 5'h1B);
    mem[{5'h10, 5'd3}] = 16'h0980;
    err_at = 2;
    run_init("R10 error");
    check(status == 2'd3 && !ready, "R10 access error status", status, 3);
    for (n = 0; n < 20; n++) @(negedge clk);
    check(n_acc == 3, "R10 no access after error", n_acc, 3);
    check(mem[{5'h10, 5'd4}] == pat(16), "R10 failed write left port", mem[{5'h10, 5'd4}], pat(16));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    setup(5'h10, 5'h1B);
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_primary();
    t_fallback_and_ports();
    t_unknown();
    t_absent();
    t_timeout();
    t_accerr();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule